// File: doc/BRIEF.md
# A/D Sample FIFO with Fill-Threshold Interrupt

This block buffers conversion results from an analog-to-digital converter until a host drains them. The converter side pushes 16-bit samples in with a single-cycle write strobe. The host side pops them out oldest first with a read strobe. The buffer holds 48 samples. Its fill level is always visible, and a write that arrives while it is full is dropped and recorded in a sticky overflow flag.

The host programs a fill threshold. When the number of stored samples climbs to that level, a sticky interrupt flag rises. A status byte mirrors this flag at bit 4 and the overflow flag at bit 0. The usual interrupt routine works in three steps:
- read the status byte;
- pop the threshold's worth of samples;
- pulse the clear strobe.

A flush strobe empties the buffer and drops both flags without a full reset. Threshold writes are clamped into the legal range, and the register reads back the clamped value.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the fill level is 0, the overflow flag, the interrupt flag and the status byte are 0, `rd_data` is 0, and the threshold reads back 1.
- R2: Samples come out in the order they were accepted. `rd_data` shows the popped sample on the cycle after `rd_en` is sampled high on a non-empty buffer.
- R3: `fill_level` rises by one for each accepted write and falls by one for each accepted read. A read and a write in the same cycle on a non-empty, non-full buffer leave it unchanged.
- R4: A write while `fill_level` is 48 is discarded, with or without a read in the same cycle. It sets `overflow` (status bit 0), which stays set until reset or flush. Draining then returns only the 48 samples that were accepted.
- R5: A read of an empty buffer leaves `fill_level` at 0 and holds `rd_data` at the last value popped.
- R6: The threshold write takes a 6-bit value. A value of 0 is stored as 1, a value above 48 is stored as 48, and `thr_rdata` returns the stored value in bits 5:0 with bits 7:6 zero, one cycle after the write.
- R7: When `fill_level` changes from below the threshold to at or above it, `irq` and status bit 4 rise one cycle later.
- R8: `irq` stays set until `irq_clr`. A clear while the level is still at or above the threshold leaves it low. It rises again only after the level has dropped below the threshold and then reached it again.
- R9: `flush` empties the buffer (`fill_level` 0) and clears `overflow` and `irq`. It leaves the threshold and `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the buffer and clears both flags |
| wr_en | input | 1 | Converter write strobe |
| wr_data | input | 16 | Sample to store |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Registered oldest sample |
| fill_level | output | 6 | Number of stored samples |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 6 | Threshold value to write |
| thr_rdata | output | 8 | Clamped threshold, zero-extended |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky threshold interrupt |
| overflow | output | 1 | Sticky dropped-write flag |
| status | output | 8 | Bit 4 interrupt, bit 0 overflow, others zero |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any checked behaviour. They also assume that every strobe is a clean level sampled at the rising edge. The overflow and empty-read properties further assume that `flush` is low in the cycle being judged, since `flush` takes priority over any read or write. The stimulus drives all strobes from the falling edge, leaves reset asserted over several edges, and never combines `flush` with any other strobe.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int SAMPLE_W = 16;
  localparam int FIFO_DEPTH = 48;
  localparam int STAT_W = 8;
  localparam int IRQ_BIT = 4;
  localparam int OVF_BIT = 0;
endpackage

// File: rtl/adcq_ram.sv
module adcq_ram #(
  parameter int W = 16,
  parameter int DEPTH = 48,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl #(
  parameter int DEPTH = 48,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic full, empty;

  always_comb begin
    full  = (count == FULL_C);
    empty = (count == '0);
    wr_ok = wr_en && !full && !flush;
    rd_ok = rd_en && !empty && !flush;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST_P) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST_P) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_C);

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en && !flush) |=> (ovf && count == FULL_C));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flush) |=> ovf);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && empty && !flush) |=> (count == '0));
endmodule

// File: rtl/adcq_thresh.sv
module adcq_thresh #(
  parameter int DEPTH = 48,
  parameter int BUS_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CW-1:0]    wdata,
  output logic [CW-1:0]    thr,
  output logic [BUS_W-1:0] rdata
);
  localparam logic [CW-1:0] MAX_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] clamped;

  always_comb begin
    if (wdata == '0)       clamped = ONE_C;
    else if (wdata > MAX_C) clamped = MAX_C;
    else                    clamped = wdata;
    rdata = BUS_W'(thr);
  end

  always_ff @(posedge clk) begin
    if (rst) thr <= ONE_C;
    else if (we) thr <= clamped;
  end

  // R6
  thr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (thr >= ONE_C) && (thr <= MAX_C));
endmodule

// File: rtl/adcq_irq.sv
module adcq_irq #(
  parameter int DEPTH = 48,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          clr,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thr,
  output logic          irq
);
  logic met, met_d;

  always_comb met = (count >= thr);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      met_d <= 1'b0;
      irq   <= 1'b0;
    end else begin
      met_d <= met;
      if (met && !met_d) irq <= 1'b1;
      else if (clr)      irq <= 1'b0;
    end
  end

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(count >= thr));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr && !flush) |=> irq);
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adcq_pkg::*;
#(
  parameter int W = SAMPLE_W,
  parameter int DEPTH = FIFO_DEPTH,
  parameter int BUS_W = STAT_W,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [CW-1:0]    fill_level,
  input  logic             thr_we,
  input  logic [CW-1:0]    thr_wdata,
  output logic [BUS_W-1:0] thr_rdata,
  input  logic             irq_clr,
  output logic             irq,
  output logic             overflow,
  output logic [BUS_W-1:0] status
);
  logic          wr_ok, rd_ok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] thr;

  adcq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
    .count(fill_level), .ovf(overflow)
  );

  adcq_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(wr_ok), .waddr(wptr), .wdata(wr_data),
    .re(rd_ok), .raddr(rptr), .rdata(rd_data)
  );

  adcq_thresh #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_thr (
    .clk(clk), .rst(rst), .we(thr_we), .wdata(thr_wdata),
    .thr(thr), .rdata(thr_rdata)
  );

  adcq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .flush(flush), .clr(irq_clr),
    .count(fill_level), .thr(thr), .irq(irq)
  );

  always_comb begin
    status = '0;
    status[IRQ_BIT] = irq;
    status[OVF_BIT] = overflow;
  end

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill_level == '0 && !overflow && !irq));
endmodule

// File: tb/test_adc_sample_fifo.sv
module test_adc_sample_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [5:0]  fill_level;
  logic        thr_we = 1'b0;
  logic [5:0]  thr_wdata = '0;
  logic [7:0]  thr_rdata;
  logic        irq_clr = 1'b0;
  logic        irq, overflow;
  logic [7:0]  status;

  adc_sample_fifo i_adc_sample_fifo (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fill_level(fill_level),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .thr_rdata(thr_rdata),
    .irq_clr(irq_clr), .irq(irq), .overflow(overflow), .status(status)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  int mcount = 0;
  logic [15:0] last_pop = '0;
  logic pend = 1'b0;
  logic [15:0] pend_val = '0;
  logic done = 1'b0;

  task automatic expect_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Driver: one clock of stimulus, pushing expected samples into the scoreboard
  task automatic cyc(input logic w, input logic [15:0] d, input logic r);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    flush = 1'b0; irq_clr = 1'b0; thr_we = 1'b0;
    if (r) begin
      if (mcount > 0) begin
        last_pop = exp_q.pop_front();
        mcount--;
      end
      pend_val = last_pop;
      pend = 1'b1;
    end
    if (w) begin
      if (mcount < DEPTH + (r && mcount > 0 ? 0 : 0) && !(mcount == DEPTH)) begin
        exp_q.push_back(d);
        mcount++;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0; irq_clr = 1'b0; thr_we = 1'b0;
  endtask

  task automatic set_thr(input logic [5:0] v);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; thr_we = 1'b1; thr_wdata = v;
  endtask

  // Monitor: compares each popped sample one cycle after the read
  always @(posedge clk) begin
    #2;
    if (pend) begin
      pend = 1'b0;
      expect_eq("R2 sample order", int'(rd_data), int'(pend_val));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1 fill", fill_level, 0);
    expect_eq("R1 irq", irq, 0);
    expect_eq("R1 overflow", overflow, 0);
    expect_eq("R1 status", status, 0);
    expect_eq("R1 rd_data", rd_data, 0);
    expect_eq("R1 thr", thr_rdata, 1);

    // R6 clamping
    set_thr(6'd0);  idle(); expect_eq("R6 zero->1", thr_rdata, 1);
    set_thr(6'd60); idle(); expect_eq("R6 60->48", thr_rdata, 48);
    set_thr(6'd48); idle(); expect_eq("R6 48 kept", thr_rdata, 48);
    set_thr(6'd5);  idle(); expect_eq("R6 5 kept", thr_rdata, 5);

    // R3 / R7
    for (int i = 0; i < 4; i++) cyc(1'b1, 16'h1000 + 16'(i), 1'b0);
    idle();
    expect_eq("R3 fill 4", fill_level, 4);
    expect_eq("R7 irq below thr", irq, 0);
    cyc(1'b1, 16'h1004, 1'b0);
    idle();
    expect_eq("R3 fill 5", fill_level, 5);
    expect_eq("R7 irq not yet", irq, 0);
    idle();
    expect_eq("R7 irq set", irq, 1);
    expect_eq("R7 status bit4", status, 8'h10);

    // R3 simultaneous read and write
    cyc(1'b1, 16'h2000, 1'b1);
    idle();
    expect_eq("R3 rd+wr level", fill_level, 5);

    // R8 clear while level still met
    @(negedge clk); irq_clr = 1'b1;
    idle();
    expect_eq("R8 cleared", irq, 0);
    idle();
    expect_eq("R8 no re-set while met", irq, 0);
    cyc(1'b0, 16'h0, 1'b1);
    idle();
    expect_eq("R8 fill 4", fill_level, 4);
    cyc(1'b1, 16'h2001, 1'b0);
    idle();
    expect_eq("R8 not yet", irq, 0);
    idle();
    expect_eq("R8 re-armed set", irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    idle();

    // Drain, then R5 empty read
    for (int i = 0; i < 5; i++) cyc(1'b0, 16'h0, 1'b1);
    idle();
    expect_eq("R3 drained", fill_level, 0);
    cyc(1'b0, 16'h0, 1'b1);
    idle();
    expect_eq("R5 empty level", fill_level, 0);
    expect_eq("R5 held data", rd_data, int'(last_pop));

    // R4 overflow
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 16'h3000 + 16'(i), 1'b0);
    idle();
    expect_eq("R4 full", fill_level, 48);
    expect_eq("R4 no ovf yet", overflow, 0);
    cyc(1'b1, 16'hDEAD, 1'b0);
    idle();
    expect_eq("R4 ovf set", overflow, 1);
    expect_eq("R4 level held", fill_level, 48);
    expect_eq("R4 status bits", status, 8'h11);
    cyc(1'b1, 16'hBEEF, 1'b1);
    idle();
    expect_eq("R4 full write with read dropped", fill_level, 47);
    for (int i = 0; i < DEPTH - 1; i++) cyc(1'b0, 16'h0, 1'b1);
    idle();
    expect_eq("R4 drained", fill_level, 0);
    expect_eq("R4 ovf sticky", overflow, 1);

    // R9 flush
    for (int i = 0; i < 6; i++) cyc(1'b1, 16'h4000 + 16'(i), 1'b0);
    idle(); idle();
    expect_eq("R9 irq before flush", irq, 1);
    @(negedge clk); flush = 1'b1;
    exp_q.delete(); mcount = 0;
    idle();
    expect_eq("R9 level", fill_level, 0);
    expect_eq("R9 overflow", overflow, 0);
    expect_eq("R9 irq", irq, 0);
    expect_eq("R9 thr kept", thr_rdata, 5);
    expect_eq("R9 rd_data kept", rd_data, int'(last_pop));
    cyc(1'b1, 16'h5555, 1'b0);
    cyc(1'b0, 16'h0, 1'b1);
    idle(); idle();
    expect_eq("R9 usable after flush", fill_level, 0);

    finish_run();
  end
endmodule